// File: doc/BRIEF.md
# RISC Instruction Decoder and Control Unit

This block turns one 16-bit instruction word of a single-cycle, Harvard-style RISC core into the control signals the datapath needs within the same cycle. It is purely combinational. From the word it produces the following:

- the two register-file read addresses;
- the destination register address and its write enable;
- a 3-bit ALU function code;
- a select that feeds either register B or the sign-extended offset to the ALU B input;
- memory read and write strobes;
- a write-back source select;
- three control-transfer flags.

The sign-extended 6-bit offset and the raw 12-bit jump field are also driven out, for the address adder and the program-counter logic.

The opcode sits in the top four bits. Below it are three 3-bit register fields. Loads, stores and the two conditional branches reuse the lowest six bits as a signed offset. Opcodes with no assigned meaning decode to a bubble: nothing is written and control does not transfer. The register file, memories, ALU and program counter are outside this block.

Top module: `rdec_top`

## Requirements
- R1: `rd_addr_a` always equals instr[11:9] and `rd_addr_b` always equals instr[8:6], whatever the opcode.
- R2: `wr_addr` is instr[5:3] for opcodes 0010 to 1001, instr[8:6] for load (0000), and 000 for every other opcode.
- R3: `reg_we` is 1 exactly for load (0000) and the eight data opcodes 0010 to 1001.
- R4: `alu_op` is 000 for add (0010), 001 for subtract (0011), 010 for invert (0100), 011 for shift left (0101), 100 for shift right (0110), 101 for AND (0111), 110 for OR (1000) and 111 for set-less-than (1001).
- R5: Load (0000) and store (0001) drive `alu_op`=000 with `alu_b_imm`=1. Branch-equal (1011) and branch-not-equal (1100) drive `alu_op`=001 with `alu_b_imm`=0. `alu_b_imm` is 0 for all other opcodes.
- R6: `mem_re` and `wb_sel_mem` are 1 only for load (0000). `mem_we` is 1 only for store (0001).
- R7: `branch_eq` is 1 only for 1011, `branch_ne` only for 1100 and `jump` only for 1101. At most one of the three is high.
- R8: `imm_sext` is instr[5:0] sign-extended to 16 bits, and `jump_ofs` equals instr[11:0].
- R9: Opcodes 1010, 1110 and 1111 drive every enable, select and transfer flag to 0 and `alu_op` to 000.
- R10: `reg_we` and `mem_we` are never high together, and no memory write coincides with a control transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction word being decoded |
| rd_addr_a | output | 3 | Register-file read address for operand A |
| rd_addr_b | output | 3 | Register-file read address for operand B / store data |
| wr_addr | output | 3 | Destination register address |
| reg_we | output | 1 | Register-file write enable |
| alu_op | output | 3 | ALU function code |
| alu_b_imm | output | 1 | 1: ALU B input takes imm_sext; 0: register B |
| mem_re | output | 1 | Data-memory read enable |
| mem_we | output | 1 | Data-memory write enable |
| wb_sel_mem | output | 1 | 1: write-back from memory; 0: from ALU |
| branch_eq | output | 1 | Branch if operands are equal |
| branch_ne | output | 1 | Branch if operands differ |
| jump | output | 1 | Unconditional jump |
| imm_sext | output | 16 | Sign-extended 6-bit offset |
| jump_ofs | output | 12 | Raw 12-bit jump field |

## Verification
Two decisions are taken from the same word in the same cycle, and they can collide: the register-write decision and the memory-write or control-transfer decision. A wrong decode of a single opcode could assert a register write together with a store or a branch.

The bench drives every one of the sixteen opcodes. Each word carries varied register fields and offsets, including the most negative and the most positive offset. For every word it checks the full control set against a hand-written expected vector, and it confirms that the write and transfer strobes stay exclusive. The sign-extension edge and bits [2:0] of data-processing opcodes being nonzero are covered by directed words.

// File: rtl/rdec_pkg.sv
// Package: shared opcode encodings, ALU codes and the decoded-control record
// for the instruction decoder. Assumes a 4-bit opcode in the top bits.
package rdec_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 4'b0000,
        OPC_STORE = 4'b0001,
        OPC_ADD   = 4'b0010,
        OPC_SUB   = 4'b0011,
        OPC_INV   = 4'b0100,
        OPC_SHL   = 4'b0101,
        OPC_SHR   = 4'b0110,
        OPC_AND   = 4'b0111,
        OPC_OR    = 4'b1000,
        OPC_SLT   = 4'b1001,
        OPC_RSV_A = 4'b1010,
        OPC_BREQ  = 4'b1011,
        OPC_BRNE  = 4'b1100,
        OPC_JUMP  = 4'b1101,
        OPC_RSV_E = 4'b1110,
        OPC_RSV_F = 4'b1111
    } opcode_e;

    localparam logic [ALUOP_W-1:0] ALU_ADD = 3'b000;
    localparam logic [ALUOP_W-1:0] ALU_SUB = 3'b001;
    localparam logic [ALUOP_W-1:0] ALU_INV = 3'b010;
    localparam logic [ALUOP_W-1:0] ALU_SHL = 3'b011;
    localparam logic [ALUOP_W-1:0] ALU_SHR = 3'b100;
    localparam logic [ALUOP_W-1:0] ALU_AND = 3'b101;
    localparam logic [ALUOP_W-1:0] ALU_OR  = 3'b110;
    localparam logic [ALUOP_W-1:0] ALU_SLT = 3'b111;

    // Which instruction field names the destination register
    typedef enum logic [1:0] {
        WSEL_NONE = 2'd0,
        WSEL_LOW  = 2'd1,   // third register field
        WSEL_MID  = 2'd2    // second register field
    } wsel_e;

    typedef struct packed {
        logic  reg_we;
        wsel_e wsel;
        logic  b_imm;
        logic  mem_re;
        logic  mem_we;
        logic  wb_mem;
        logic  br_eq;
        logic  br_ne;
        logic  jmp;
    } ctl_t;

endpackage

// File: rtl/rdec_class.sv
// Module: opcode classifier. Maps the 4-bit opcode to the enable, select and
// transfer flags. Assumes unassigned opcodes must behave as a bubble.
module rdec_class
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctl_t             ctl
);

    // Purpose: one case over the opcode, defaults give a bubble
    always_comb begin
        ctl = '0;
        ctl.wsel = WSEL_NONE;
        case (opcode_e'(opc))
            OPC_LOAD: begin
                ctl.reg_we = 1'b1;
                ctl.wsel   = WSEL_MID;
                ctl.b_imm  = 1'b1;
                ctl.mem_re = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_imm  = 1'b1;
                ctl.mem_we = 1'b1;
            end
            OPC_ADD, OPC_SUB, OPC_INV, OPC_SHL,
            OPC_SHR, OPC_AND, OPC_OR,  OPC_SLT: begin
                ctl.reg_we = 1'b1;
                ctl.wsel   = WSEL_LOW;
            end
            OPC_BREQ: ctl.br_eq = 1'b1;
            OPC_BRNE: ctl.br_ne = 1'b1;
            OPC_JUMP: ctl.jmp   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rdec_alu_map.sv
// Module: ALU function selector. Memory opcodes add, branches subtract so the
// ALU zero flag shows equality; everything unassigned falls back to add.
module rdec_alu_map
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    output logic [ALUOP_W-1:0] alu_op
);

    // Purpose: fixed opcode-to-ALU-code table
    always_comb begin
        case (opcode_e'(opc))
            OPC_SUB:            alu_op = ALU_SUB;
            OPC_INV:            alu_op = ALU_INV;
            OPC_SHL:            alu_op = ALU_SHL;
            OPC_SHR:            alu_op = ALU_SHR;
            OPC_AND:            alu_op = ALU_AND;
            OPC_OR:             alu_op = ALU_OR;
            OPC_SLT:            alu_op = ALU_SLT;
            OPC_BREQ, OPC_BRNE: alu_op = ALU_SUB;
            default:            alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/rdec_fields.sv
// Module: field extractor. Slices the register fields, sign-extends the short
// offset and passes the long jump field. Assumes DATA_W >= the offset width.
module rdec_fields #(
    parameter int INSTR_W = 16,
    parameter int RADDR_W = 3,
    parameter int OPC_W   = 4,
    parameter int DATA_W  = 16
) (
    input  logic [INSTR_W-1:0]       instr,
    output logic [RADDR_W-1:0]       fld_a,
    output logic [RADDR_W-1:0]       fld_b,
    output logic [RADDR_W-1:0]       fld_c,
    output logic [DATA_W-1:0]        imm_sext,
    output logic [INSTR_W-OPC_W-1:0] jump_ofs
);

    localparam int JOFS_W = INSTR_W - OPC_W;
    localparam int A_LSB  = JOFS_W - RADDR_W;
    localparam int B_LSB  = A_LSB - RADDR_W;
    localparam int C_LSB  = B_LSB - RADDR_W;
    localparam int MOFS_W = B_LSB;

    // Purpose: fixed-position slicing of the three register fields
    always_comb begin
        fld_a    = instr[A_LSB +: RADDR_W];
        fld_b    = instr[B_LSB +: RADDR_W];
        fld_c    = instr[C_LSB +: RADDR_W];
        jump_ofs = instr[JOFS_W-1:0];
    end

    generate
        if (DATA_W > MOFS_W) begin : g_ext
            // Purpose: replicate the offset sign bit into the upper bits
            always_comb imm_sext = {{(DATA_W-MOFS_W){instr[MOFS_W-1]}},
                                    instr[MOFS_W-1:0]};
        end else begin : g_trunc
            // Purpose: offset already fills the data width
            always_comb imm_sext = instr[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rdec_top.sv
// Module: instruction decoder top. Combines the opcode classifier, the ALU
// code map and the field extractor into the datapath control set. Purely
// combinational; assumes the instruction word is stable for the cycle.
module rdec_top
    import rdec_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int RADDR_W = 3,
    parameter int DATA_W  = 16
) (
    input  logic [INSTR_W-1:0]       instr,
    output logic [RADDR_W-1:0]       rd_addr_a,
    output logic [RADDR_W-1:0]       rd_addr_b,
    output logic [RADDR_W-1:0]       wr_addr,
    output logic                     reg_we,
    output logic [ALUOP_W-1:0]       alu_op,
    output logic                     alu_b_imm,
    output logic                     mem_re,
    output logic                     mem_we,
    output logic                     wb_sel_mem,
    output logic                     branch_eq,
    output logic                     branch_ne,
    output logic                     jump,
    output logic [DATA_W-1:0]        imm_sext,
    output logic [INSTR_W-OPC_W-1:0] jump_ofs
);

    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0]   opc;
    ctl_t               ctl;
    logic [RADDR_W-1:0] fld_c;

    assign opc = instr[INSTR_W-1:OPC_LSB];

    rdec_class u_class (
        .opc (opc),
        .ctl (ctl)
    );

    rdec_alu_map u_alu (
        .opc    (opc),
        .alu_op (alu_op)
    );

    rdec_fields #(
        .INSTR_W (INSTR_W),
        .RADDR_W (RADDR_W),
        .OPC_W   (OPC_W),
        .DATA_W  (DATA_W)
    ) u_fields (
        .instr    (instr),
        .fld_a    (rd_addr_a),
        .fld_b    (rd_addr_b),
        .fld_c    (fld_c),
        .imm_sext (imm_sext),
        .jump_ofs (jump_ofs)
    );

    // Purpose: pick the destination field named by the classifier
    always_comb begin
        case (ctl.wsel)
            WSEL_LOW: wr_addr = fld_c;
            WSEL_MID: wr_addr = rd_addr_b;
            default:  wr_addr = '0;
        endcase
    end

    // Purpose: drive the flag outputs from the classifier record
    always_comb begin
        reg_we     = ctl.reg_we;
        alu_b_imm  = ctl.b_imm;
        mem_re     = ctl.mem_re;
        mem_we     = ctl.mem_we;
        wb_sel_mem = ctl.wb_mem;
        branch_eq  = ctl.br_eq;
        branch_ne  = ctl.br_ne;
        jump       = ctl.jmp;
    end

    // Purpose: cross-checks between the classifier and the ALU map
    always_comb begin
        AST_ONE_TRANSFER: assert ($onehot0({branch_eq, branch_ne, jump})); // R7
        AST_NO_WE_CLASH: assert (!(reg_we && mem_we)); // R10
        AST_STORE_NO_XFER: assert (!(mem_we && (branch_eq || branch_ne || jump))); // R10
        AST_BRANCH_SUBTRACTS: assert (!(branch_eq || branch_ne) || alu_op == ALU_SUB); // R5
        AST_IMM_MEM_ONLY: assert (!alu_b_imm || ((mem_re || mem_we) && alu_op == ALU_ADD)); // R5
        AST_RSV_BUBBLE: assert (!(opc == 4'b1010 || opc == 4'b1110 || opc == 4'b1111)
                                || (alu_op == ALU_ADD && !reg_we && !mem_we && !mem_re)); // R9
    end

endmodule

// File: tb/rdec_top_test.sv
module rdec_top_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [15:0] instr;
    logic [2:0]  rd_addr_a, rd_addr_b, wr_addr, alu_op;
    logic        reg_we, alu_b_imm, mem_re, mem_we, wb_sel_mem;
    logic        branch_eq, branch_ne, jump;
    logic [15:0] imm_sext;
    logic [11:0] jump_ofs;

    int checks = 0;
    int errors = 0;

    rdec_top uut (
        .instr(instr), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr(wr_addr), .reg_we(reg_we), .alu_op(alu_op),
        .alu_b_imm(alu_b_imm), .mem_re(mem_re), .mem_we(mem_we),
        .wb_sel_mem(wb_sel_mem), .branch_eq(branch_eq),
        .branch_ne(branch_ne), .jump(jump), .imm_sext(imm_sext),
        .jump_ofs(jump_ofs)
    );

    // {instr, reg_we, alu_op[2:0], b_imm, mem_re, mem_we, wb_mem, beq, bne, jmp}
    localparam logic [26:0] VEC [16] = '{
        {16'h0ABF, 11'b10001101000},  // load
        {16'h179F, 11'b00001010000},  // store
        {16'h2298, 11'b10000000000},  // add
        {16'h3E28, 11'b10010000000},  // sub
        {16'h4830, 11'b10100000000},  // invert
        {16'h54F8, 11'b10110000000},  // shift left
        {16'h6048, 11'b11000000000},  // shift right
        {16'h7D60, 11'b11010000000},  // and
        {16'h86D0, 11'b11100000000},  // or
        {16'h9BB8, 11'b11110000000},  // set-less-than
        {16'hAFFF, 11'b00000000000},  // reserved
        {16'hB2A0, 11'b00010000100},  // branch equal
        {16'hC901, 11'b00010000010},  // branch not equal
        {16'hDABC, 11'b00000000001},  // jump
        {16'hE123, 11'b00000000000},  // reserved
        {16'hF000, 11'b00000000000}   // reserved
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_wr(input logic [15:0] w);
        if (w[15:12] == 4'b0000) return w[8:6];
        if (w[15:12] >= 4'b0010 && w[15:12] <= 4'b1001) return w[5:3];
        return 3'b000;
    endfunction

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        instr = w;
        @(posedge clk);
        #2;
    endtask

    task automatic check_fields(input logic [15:0] w);
        chk("R1", "rd_addr_a", int'(rd_addr_a), int'(w[11:9]));
        chk("R1", "rd_addr_b", int'(rd_addr_b), int'(w[8:6]));
        chk("R2", "wr_addr", int'(wr_addr), int'(exp_wr(w)));
        chk("R8", "imm_sext", int'(imm_sext), int'({{10{w[5]}}, w[5:0]}));
        chk("R8", "jump_ofs", int'(jump_ofs), int'(w[11:0]));
        chk("R10", "we clash", int'(reg_we && mem_we), 0);
    endtask

    initial begin
        instr = 16'h0000;
        // Watchdog: a hung run counts as one failed check
        fork
            begin
                #100000;
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        // Initial decode of the all-zero word is a load
        apply(16'h0000);
        chk("R6", "initial mem_re", int'(mem_re), 1);
        chk("R3", "initial reg_we", int'(reg_we), 1);

        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            logic [10:0] e;
            w = VEC[i][26:11];
            e = VEC[i][10:0];
            apply(w);
            chk("R3", "reg_we", int'(reg_we), int'(e[10]));
            chk("R4/R5", "alu_op", int'(alu_op), int'(e[9:7]));
            chk("R5", "alu_b_imm", int'(alu_b_imm), int'(e[6]));
            chk("R6", "mem_re", int'(mem_re), int'(e[5]));
            chk("R6", "mem_we", int'(mem_we), int'(e[4]));
            chk("R6", "wb_sel_mem", int'(wb_sel_mem), int'(e[3]));
            chk("R7", "branch_eq", int'(branch_eq), int'(e[2]));
            chk("R7", "branch_ne", int'(branch_ne), int'(e[1]));
            chk("R7", "jump", int'(jump), int'(e[0]));
            if (w[15:12] == 4'hA || w[15:12] == 4'hE || w[15:12] == 4'hF)
                chk("R9", "bubble flags",
                    int'({reg_we, mem_re, mem_we, alu_b_imm, branch_eq, branch_ne, jump}), 0);
            check_fields(w);
        end

        // Directed: most negative and most positive load offsets
        apply(16'h0E20);
        chk("R8", "imm -32", int'(imm_sext), int'(16'hFFE0));
        chk("R2", "load dest", int'(wr_addr), 0);
        apply(16'h001F);
        chk("R8", "imm +31", int'(imm_sext), int'(16'h001F));

        // Directed: data opcode with nonzero low bits keeps the destination field
        apply(16'h2FFF);
        chk("R2", "add dest", int'(wr_addr), 7);
        chk("R4", "add code", int'(alu_op), 0);

        // Directed: branch with full register fields still writes nothing
        apply(16'hBFFF);
        chk("R3", "branch no write", int'(reg_we), 0);
        chk("R2", "branch dest", int'(wr_addr), 0);

        // Directed: store with full fields, no transfer
        apply(16'h1FFF);
        chk("R10", "store no transfer", int'({branch_eq, branch_ne, jump}), 0);
        chk("R2", "store dest", int'(wr_addr), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule